// File: doc/BRIEF.md
# Direct-Mapped Byte Cache with Selectable Write Policy

This block sits between a processor port that reads and writes single bytes and a slower main memory that moves whole blocks. Every processor address is cut into three fields: a tag in the top bits, a line index in the middle and a byte offset in the bottom bits. The index picks exactly one line. A hit on that line is served from the local data store. A miss copies the complete block from memory into the line, replaces the line's tag, and then delivers the byte.

The `wb_mode` input chooses the write policy and is sampled on each lookup. When it is low (write-through), every store goes to memory as a single-lane block write. A store that hits also updates the line, and a store that misses allocates nothing. When it is high (write-back), a store changes only the cache line and marks it dirty. A write miss first fetches the block, then merges the byte. A dirty line is always copied back to memory as a full block before it is refilled, whichever policy is active at that moment.

The geometry is set by three parameters: address width, block bytes and cache bytes. The line count, index width and tag width are derived from them. A 24-bit address with 4-byte blocks and a 64 KB store gives an 8-bit tag and a 14-bit index. The default build uses a 1 KB store (256 lines, 14-bit tag) so that it elaborates quickly.

Top module: `dm_cache_ctrl`

## Requirements
- R1: After synchronous reset every line is invalid and clean, `cpu_ready` is high, and `mem_req` and `cpu_done` are low. The first access to any address is therefore a miss.
- R2: The byte offset is `addr[1:0]`, the index is the next IDX_W bits and the tag is the remaining top bits. Two addresses that share an index but differ in tag compete for the same line.
- R3: A read that hits returns the addressed byte on `cpu_rdata` with `cpu_done` two clock edges after the request is accepted, and raises no memory request.
- R4: A read miss issues exactly one memory read at the block-aligned address. The line is refilled, the correct byte is returned, and a later access to the same block hits.
- R5: A write-through store issues exactly one memory write. Only the `mem_be` bit equal to the offset is set, and the byte sits in lane k at `mem_wdata[8k+7:8k]`. On a hit the line is updated as well, and a later read returns the new byte with no traffic.
- R6: A write-through store that misses performs no fill and leaves the line untouched, so a later read of that block misses.
- R7: A write-back store that hits changes only the line and marks it dirty. No memory request is made and memory keeps its old byte.
- R8: A write-back store that misses fetches the block with one read, merges the byte and marks the line dirty, without any memory write.
- R9: Before a dirty line is refilled, the controller writes the old block to memory with all `mem_be` bits set, at the address formed from the stored tag and the index. Only then does it issue the fill read. This holds under either policy.
- R10: Once raised, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_ack` is high.
- R11: `cpu_ready` is low from the edge that accepts a request until `cpu_done` pulses for one cycle. `cpu_done` is only ever high while `cpu_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_mode | input | 1 | 1 selects write-back, 0 selects write-through |
| cpu_req | input | 1 | Processor request, accepted when `cpu_ready` is high |
| cpu_we | input | 1 | 1 for a byte store, 0 for a byte load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_ready | output | 1 | Controller idle and able to accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Load result, valid with `cpu_done` |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for a block write, 0 for a block read |
| mem_addr | output | ADDR_W | Block-aligned memory address |
| mem_be | output | BLK_BYTES | Byte-lane enables for writes |
| mem_wdata | output | 8*BLK_BYTES | Write block |
| mem_rdata | input | 8*BLK_BYTES | Read block, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of the current transfer |

## Verification
Two functions can meet on the same lookup. The policy input may change in the very cycle that a dirty line is found to be the victim. Likewise, the acknowledge that ends the victim write-back is the edge that turns the request into the fill read. The bench provokes both cases. It leaves lines dirty under write-back, switches to write-through, and then misses on the same index with another tag. The random phase does the same by redrawing the policy before every operation over a small pool of colliding tags. The bench judges each case in two ways. Its memory model logs the order of transfers: a full-lane write at the old tag's address must come before the read. Every later load must also match a flat reference array of what the processor wrote.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU
    } dmc_state_e;

    typedef enum logic [2:0] {
        DEC_RD_HIT,
        DEC_WR_HIT_WB,
        DEC_WR_THRU,
        DEC_EVICT,
        DEC_FILL
    } dmc_dec_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int unsigned LINES = 256,
    parameter int unsigned IDX_W = 8,
    parameter int unsigned TAG_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_en,
    input  logic [IDX_W-1:0] mark_idx
);

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (fill_en) begin
                valid_q[fill_idx] <= 1'b1;
                dirty_q[fill_idx] <= 1'b0;
            end else if (mark_en) begin
                dirty_q[mark_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx] <= fill_tag;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

    AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (valid_q[$past(fill_idx)] && !dirty_q[$past(fill_idx)])); // R4

    AST_MARK_DIRTY: assert property (@(posedge clk) disable iff (rst)
        (mark_en && !fill_en) |=> dirty_q[$past(mark_idx)]); // R7

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int unsigned LINES     = 256,
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned BLK_BYTES = 4,
    parameter int unsigned OFF_W     = 2
) (
    input  logic                      clk,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [8*BLK_BYTES-1:0]    rd_line,
    input  logic                      fill_en,
    input  logic [IDX_W-1:0]          fill_idx,
    input  logic [8*BLK_BYTES-1:0]    fill_line,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [OFF_W-1:0]          wr_off,
    input  logic [dmc_pkg::BYTE_W-1:0] wr_byte
);

    for (genvar b = 0; b < BLK_BYTES; b++) begin : g_lane
        logic [7:0] lane_q [LINES];

        always_ff @(posedge clk) begin
            if (fill_en) begin
                lane_q[fill_idx] <= fill_line[b*8 +: 8];
            end else if (wr_en && (wr_off == OFF_W'(b))) begin
                lane_q[wr_idx] <= wr_byte;
            end
        end

        assign rd_line[b*8 +: 8] = lane_q[rd_idx];
    end

endmodule

// File: rtl/dmc_lookup.sv
module dmc_lookup #(
    parameter int unsigned TAG_W = 14
) (
    input  logic             req_we,
    input  logic             wb_mode,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             line_valid,
    input  logic             line_dirty,
    input  logic [TAG_W-1:0] line_tag,
    output logic             hit,
    output dmc_pkg::dmc_dec_e decision
);

    import dmc_pkg::*;

    always_comb begin
        hit = line_valid && (line_tag == req_tag);
        if (hit) begin
            if (!req_we)      decision = DEC_RD_HIT;
            else if (wb_mode) decision = DEC_WR_HIT_WB;
            else              decision = DEC_WR_THRU;
        end else begin
            if (req_we && !wb_mode)         decision = DEC_WR_THRU;
            else if (line_valid && line_dirty) decision = DEC_EVICT;
            else                            decision = DEC_FILL;
        end
    end

endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl #(
    parameter int unsigned ADDR_W      = 24,
    parameter int unsigned BLK_BYTES   = 4,
    parameter int unsigned CACHE_BYTES = 1024,
    localparam int unsigned OFF_W = $clog2(BLK_BYTES),
    localparam int unsigned LINES = CACHE_BYTES / BLK_BYTES,
    localparam int unsigned IDX_W = $clog2(LINES),
    localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W,
    localparam int unsigned BLK_W = 8 * BLK_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_mode,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [7:0]        cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BLK_BYTES-1:0] mem_be,
    output logic [BLK_W-1:0]  mem_wdata,
    input  logic [BLK_W-1:0]  mem_rdata,
    input  logic              mem_ack
);

    import dmc_pkg::*;

    dmc_state_e        state;
    logic              req_we;
    logic [ADDR_W-1:0] req_addr;
    logic [7:0]        req_wdata;

    logic [OFF_W-1:0]  req_off;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;

    logic              line_valid;
    logic              line_dirty;
    logic [TAG_W-1:0]  line_tag;
    logic [BLK_W-1:0]  line_data;
    logic [7:0]        hit_byte;
    logic              hit;
    dmc_dec_e          decision;

    logic              fill_en;
    logic              wr_en;
    logic              mark_en;

    assign req_off = req_addr[OFF_W-1:0];
    assign req_idx = req_addr[OFF_W +: IDX_W];
    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

    dmc_tag_store #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (req_idx),
        .rd_valid (line_valid),
        .rd_dirty (line_dirty),
        .rd_tag   (line_tag),
        .fill_en  (fill_en),
        .fill_idx (req_idx),
        .fill_tag (req_tag),
        .mark_en  (mark_en),
        .mark_idx (req_idx)
    );

    dmc_data_store #(
        .LINES     (LINES),
        .IDX_W     (IDX_W),
        .BLK_BYTES (BLK_BYTES),
        .OFF_W     (OFF_W)
    ) u_data (
        .clk       (clk),
        .rd_idx    (req_idx),
        .rd_line   (line_data),
        .fill_en   (fill_en),
        .fill_idx  (req_idx),
        .fill_line (mem_rdata),
        .wr_en     (wr_en),
        .wr_idx    (req_idx),
        .wr_off    (req_off),
        .wr_byte   (req_wdata)
    );

    dmc_lookup #(
        .TAG_W (TAG_W)
    ) u_lookup (
        .req_we     (req_we),
        .wb_mode    (wb_mode),
        .req_tag    (req_tag),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag),
        .hit        (hit),
        .decision   (decision)
    );

    assign hit_byte = line_data[{req_off, 3'b000} +: 8];

    assign fill_en = (state == ST_FILL) && mem_ack;
    assign wr_en   = (state == ST_LOOKUP) && hit && req_we;
    assign mark_en = (state == ST_LOOKUP) && (decision == DEC_WR_HIT_WB);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            req_we    <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
            cpu_done  <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            cpu_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cpu_req) begin
                        req_we    <= cpu_we;
                        req_addr  <= cpu_addr;
                        req_wdata <= cpu_wdata;
                        state     <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    unique case (decision)
                        DEC_RD_HIT: begin
                            cpu_rdata <= hit_byte;
                            cpu_done  <= 1'b1;
                            state     <= ST_IDLE;
                        end
                        DEC_WR_HIT_WB: begin
                            cpu_done <= 1'b1;
                            state    <= ST_IDLE;
                        end
                        DEC_WR_THRU: state <= ST_WTHRU;
                        DEC_EVICT:   state <= ST_EVICT;
                        default:     state <= ST_FILL;
                    endcase
                end
                ST_EVICT: begin
                    if (mem_ack) state <= ST_FILL;
                end
                ST_FILL: begin
                    if (mem_ack) state <= ST_LOOKUP;
                end
                ST_WTHRU: begin
                    if (mem_ack) begin
                        cpu_done <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cpu_ready = (state == ST_IDLE);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {req_tag, req_idx, {OFF_W{1'b0}}};
        mem_be    = '0;
        mem_wdata = '0;
        unique case (state)
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {line_tag, req_idx, {OFF_W{1'b0}}};
                mem_be    = '1;
                mem_wdata = line_data;
            end
            ST_FILL: begin
                mem_req = 1'b1;
            end
            ST_WTHRU: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = BLK_BYTES'(1) << req_off;
                mem_wdata = {BLK_BYTES{req_wdata}};
            end
            default: ;
        endcase
    end

    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOOKUP && decision == DEC_RD_HIT) |=> (!mem_req && cpu_done)); // R3

    AST_WT_STORE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOOKUP && req_we && !wb_mode)
        |=> (mem_req && mem_we && $countones(mem_be) == 1)); // R5

    AST_WB_NO_TRAFFIC: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOOKUP && hit && req_we && wb_mode) |=> !mem_req); // R7

    AST_EVICT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOOKUP && !hit && line_valid && line_dirty && !(req_we && !wb_mode))
        |=> (mem_req && mem_we && mem_be == '1)); // R9

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack)
        |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10

    AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> cpu_ready); // R11

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_ready) |=> !cpu_ready); // R11

endmodule

// File: tb/sim_dm_cache_ctrl.sv
module sim_dm_cache_ctrl;

    localparam int AW = 24;
    localparam int BB = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wb_mode = 1'b1;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0]    cpu_wdata = '0;
    logic          cpu_ready;
    logic          cpu_done;
    logic [7:0]    cpu_rdata;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [BB-1:0] mem_be;
    logic [8*BB-1:0] mem_wdata;
    logic [8*BB-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;

    always #5 clk = ~clk;

    dm_cache_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .wb_mode   (wb_mode),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .cpu_done  (cpu_done),
        .cpu_rdata (cpu_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] phys [int];
    logic [7:0] refm [int];

    int            n_rd, n_wr;
    bit            first_wr;
    logic [AW-1:0] last_wr_addr, last_rd_addr;
    logic [BB-1:0] last_be;

    function automatic logic [7:0] init_b(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    function automatic logic [7:0] phys_get(input logic [AW-1:0] a);
        if (phys.exists(int'(a))) return phys[int'(a)];
        return init_b(a);
    endfunction

    function automatic logic [7:0] ref_get(input logic [AW-1:0] a);
        if (refm.exists(int'(a))) return refm[int'(a)];
        return init_b(a);
    endfunction

    function automatic logic [AW-1:0] mk(input logic [13:0] t, input logic [7:0] i, input logic [1:0] o);
        return {t, i, o};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model: serves one transfer per request with random latency
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && !rst) begin
                logic [AW-1:0] a0;
                a0 = mem_addr;
                repeat ($urandom_range(0, 2)) @(negedge clk);
                chk(mem_req && mem_addr == a0, "R10", "request held", mem_addr, a0);
                if (n_rd + n_wr == 0) first_wr = mem_we;
                if (mem_we) begin
                    for (int k = 0; k < BB; k++)
                        if (mem_be[k]) phys[int'(mem_addr) + k] = mem_wdata[k*8 +: 8];
                    n_wr++;
                    last_wr_addr = mem_addr;
                    last_be = mem_be;
                end else begin
                    for (int k = 0; k < BB; k++)
                        mem_rdata[k*8 +: 8] = phys_get(mem_addr + AW'(k));
                    n_rd++;
                    last_rd_addr = mem_addr;
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [7:0] wd,
                         output logic [7:0] rd, output int cyc, output bit busy_ok);
        @(negedge clk);
        n_rd = 0;
        n_wr = 0;
        first_wr = 1'b0;
        cpu_req = 1'b1;
        cpu_we = we;
        cpu_addr = a;
        cpu_wdata = wd;
        cyc = 0;
        busy_ok = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            cpu_req = 1'b0;
            if (cpu_done) break;
            if (cpu_ready) busy_ok = 1'b0;
            if (cyc > 400) break;
        end
        rd = cpu_rdata;
        if (we) refm[int'(a)] = wd;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: actual hung expected done");
        summary();
    end

    initial begin
        logic [7:0] rd;
        int cyc;
        bit bz;
        logic [AW-1:0] a_a, a_b, a_c, a_d, a_e;

        void'($urandom(32'd20240611));
        a_a = mk(14'h0011, 8'h05, 2'd2);
        a_b = mk(14'h2A40, 8'h05, 2'd1);
        a_c = mk(14'h0123, 8'h09, 2'd3);
        a_d = mk(14'h0777, 8'h0C, 2'd0);
        a_e = mk(14'h3FFF, 8'h0C, 2'd2);

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_ready == 1'b1, "R1", "ready after reset", cpu_ready, 1);
        chk(mem_req == 1'b0, "R1", "no mem request after reset", mem_req, 0);
        chk(cpu_done == 1'b0, "R1", "no done after reset", cpu_done, 0);

        // cold read miss
        wb_mode = 1'b1;
        do_op(1'b0, a_a, 8'h00, rd, cyc, bz);
        chk(n_rd == 1 && n_wr == 0, "R1", "cold access misses", n_rd, 1);
        chk(last_rd_addr == {a_a[23:2], 2'b00}, "R4", "fill address aligned", last_rd_addr, {a_a[23:2], 2'b00});
        chk(rd == ref_get(a_a), "R4", "miss data", rd, ref_get(a_a));
        chk(bz, "R11", "ready low while busy", 0, 1);

        // read hit at another offset of the same block
        do_op(1'b0, {a_a[23:2], 2'd3}, 8'h00, rd, cyc, bz);
        chk(n_rd == 0 && n_wr == 0, "R3", "hit makes no traffic", n_rd + n_wr, 0);
        chk(cyc == 2, "R3", "hit latency", cyc, 2);
        chk(rd == ref_get({a_a[23:2], 2'd3}), "R2", "offset selects byte", rd, ref_get({a_a[23:2], 2'd3}));

        // write-back store hit
        do_op(1'b1, a_a, 8'h77, rd, cyc, bz);
        chk(n_rd + n_wr == 0, "R7", "write-back hit no traffic", n_rd + n_wr, 0);
        chk(phys_get(a_a) == init_b(a_a), "R7", "memory untouched", phys_get(a_a), init_b(a_a));
        do_op(1'b0, a_a, 8'h00, rd, cyc, bz);
        chk(rd == 8'h77 && n_rd == 0, "R7", "line holds store", rd, 8'h77);

        // conflicting read evicts the dirty line
        do_op(1'b0, a_b, 8'h00, rd, cyc, bz);
        chk(n_wr == 1 && n_rd == 1 && first_wr, "R9", "write-back before fill", n_wr, 1);
        chk(last_wr_addr == {a_a[23:2], 2'b00}, "R9", "victim address from stored tag", last_wr_addr, {a_a[23:2], 2'b00});
        chk(last_be == 4'hF, "R9", "full-block write", last_be, 4'hF);
        chk(phys_get(a_a) == 8'h77, "R9", "victim byte reached memory", phys_get(a_a), 8'h77);
        chk(rd == ref_get(a_b), "R2", "same index other tag", rd, ref_get(a_b));

        // write-through hit
        wb_mode = 1'b0;
        do_op(1'b1, a_b, 8'h3C, rd, cyc, bz);
        chk(n_wr == 1 && n_rd == 0, "R5", "one memory write", n_wr, 1);
        chk(last_be == 4'b0010, "R5", "single lane enable", last_be, 4'b0010);
        chk(phys_get(a_b) == 8'h3C, "R5", "memory byte", phys_get(a_b), 8'h3C);
        do_op(1'b0, a_b, 8'h00, rd, cyc, bz);
        chk(rd == 8'h3C && n_rd + n_wr == 0, "R5", "line updated", rd, 8'h3C);

        // write-through miss: no allocate
        do_op(1'b1, a_c, 8'hE1, rd, cyc, bz);
        chk(n_wr == 1 && n_rd == 0, "R6", "store without fill", n_rd, 0);
        do_op(1'b0, a_c, 8'h00, rd, cyc, bz);
        chk(n_rd == 1, "R6", "later read misses", n_rd, 1);
        chk(rd == 8'hE1, "R6", "read sees stored byte", rd, 8'hE1);

        // write-back miss: allocate and merge
        wb_mode = 1'b1;
        do_op(1'b1, a_d, 8'h5D, rd, cyc, bz);
        chk(n_rd == 1 && n_wr == 0, "R8", "fill then merge", n_wr, 0);
        do_op(1'b0, a_d, 8'h00, rd, cyc, bz);
        chk(rd == 8'h5D && n_rd + n_wr == 0, "R8", "merged byte hits", rd, 8'h5D);

        // dirty victim under write-through policy
        wb_mode = 1'b0;
        do_op(1'b0, a_e, 8'h00, rd, cyc, bz);
        chk(n_wr == 1 && n_rd == 1 && first_wr, "R9", "dirty victim flushed in write-through", n_wr, 1);
        chk(phys_get(a_d) == 8'h5D, "R9", "victim byte in memory", phys_get(a_d), 8'h5D);
        chk(rd == ref_get(a_e), "R4", "fill data after flush", rd, ref_get(a_e));

        // random mix with colliding tags
        for (int i = 0; i < 3000; i++) begin
            logic [13:0] t;
            logic [7:0]  ix;
            logic [AW-1:0] a;
            bit w;
            logic [7:0] d;
            case ($urandom_range(0, 3))
                0: t = 14'h0000;
                1: t = 14'h0001;
                2: t = 14'h1A2B;
                default: t = 14'h3FFF;
            endcase
            ix = ($urandom_range(0, 7) == 0) ? 8'hFF : 8'($urandom_range(0, 3));
            a = mk(t, ix, 2'($urandom_range(0, 3)));
            w = ($urandom_range(0, 2) == 0);
            d = 8'($urandom);
            wb_mode = 1'($urandom_range(0, 1));
            do_op(w, a, d, rd, cyc, bz);
            if (!w) chk(rd == ref_get(a), "R4", "random load", rd, ref_get(a));
            if (!bz) chk(1'b0, "R11", "ready during operation", 1, 0);
        end

        summary();
    end

endmodule